// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of comparator timers and the two interrupt controllers of a platform: a legacy programmable interrupt controller (PIC) with sixteen request lines and an I/O APIC with twenty-four. Each timer supplies a one-cycle match strobe, a trigger-mode bit, a write-one-to-clear strobe for its pending flag, and a route field that names an IRQ number. The router turns every match into either a one-cycle pulse or a held level. It places that request on the line the route field selects, and it ORs together all requests that land on the same line.

Each timer only accepts the routes in its capability set. The router publishes that set as a read-only mask for software, and a route outside the set drives nothing. A single global override switches the first two timers onto a fixed legacy wiring while the other timers keep their own routes. This lets system firmware stand in for the old interval timer and real-time clock interrupts without reprogramming the controllers.

Top module: `timer_irq_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every bit of `pic_irq` and `apic_irq` is 0, whatever the timer inputs do.
- R2: `tmr_cap` holds one 24-bit mask per timer, timer i at bits [24i+23:24i], where bit n set means IRQ n is a legal route. Timers 0 and 1 read 0x00F00000 (IRQ20 to IRQ23). Timer 2 reads 0x00F00800 (adds IRQ11). Timer 3 reads 0x00F01000 (adds IRQ12).
- R3: With the override off, a timer whose route field holds a legal value N places its request on `apic_irq[N]`, and also on `pic_irq[N]` when N is below 16. The request appears after the second rising clock edge that follows the match strobe.
- R4: A route value whose bit is clear in the timer's capability mask, including any value of 24 or more, drives no line on either controller.
- R5: With `legacy_repl` set, timer 0 drives `pic_irq[0]` and `apic_irq[2]`, and timer 1 drives `pic_irq[8]` and `apic_irq[8]`, whatever their route fields hold.
- R6: With `legacy_repl` set, timers 2 and 3 still follow their own route fields and capability masks.
- R7: A timer whose `tmr_level` bit is 0 (edge mode) turns each match strobe into exactly one cycle on its selected line.
- R8: A timer whose `tmr_level` bit is 1 (level mode) holds its line from the match until a `tmr_clr` strobe. The line drops one cycle after the strobe's edge. A match in the same cycle as a clear leaves the line held.
- R9: When several timers select the same line, the line carries the OR of their requests, so a level line stays high until every timer holding it has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_repl | input | 1 | Global override onto the fixed legacy wiring for timers 0 and 1 |
| tmr_fire | input | NUM_TIMERS | Per-timer comparator match strobe, one cycle |
| tmr_clr | input | NUM_TIMERS | Per-timer write-one-to-clear strobe for the level-mode pending flag |
| tmr_level | input | NUM_TIMERS | Per-timer trigger mode: 1 level, 0 edge |
| tmr_route | input | NUM_TIMERS*ROUTE_W | Per-timer requested IRQ number, timer i at bits [5i+4:5i] |
| pic_irq | output | PIC_LINES | Request lines toward the legacy PIC |
| apic_irq | output | APIC_LINES | Request lines toward the I/O APIC |
| tmr_cap | output | NUM_TIMERS*APIC_LINES | Per-timer legal-route masks |

## Verification
The bench builds the router with its defaults: four timers, a 5-bit route field, 16 PIC lines and 24 APIC lines. With four timers, both the legacy override path (timers 0 and 1) and the timers with private routes (11 and 12) are reachable. A 5-bit field also reaches the out-of-range codes 24 to 31, which must stay silent. Twenty-four APIC lines put the shared block IRQ20 to IRQ23 at the top of the vector, where several timers can collide on one line and the OR merge and level hold are exercised together.

// File: rtl/trt_pkg.sv
package trt_pkg;

   localparam int unsigned MAX_TIMERS     = 4;
   localparam int unsigned PIC_LINES_DEF  = 16;
   localparam int unsigned APIC_LINES_DEF = 24;
   localparam int unsigned ROUTE_W_DEF    = 5;

   // shared APIC-only block every timer may use
   localparam int unsigned SHARED_LO = 20;
   localparam int unsigned SHARED_HI = 23;
   // private lines usable on both controllers
   localparam int unsigned T2_PRIV   = 11;
   localparam int unsigned T3_PRIV   = 12;
   // fixed override wiring
   localparam int unsigned LEG0_PIC  = 0;
   localparam int unsigned LEG0_APIC = 2;
   localparam int unsigned LEG1_LINE = 8;

   function automatic logic [31:0] route_caps(input int unsigned idx);
      logic [31:0] m;
      m = '0;
      for (int unsigned n = SHARED_LO; n <= SHARED_HI; n++) m[n] = 1'b1;
      if (idx == 2) m[T2_PRIV] = 1'b1;
      if (idx == 3) m[T3_PRIV] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] reach_apic(input int unsigned nt);
      logic [31:0] m;
      m = '0;
      for (int unsigned i = 0; i < nt; i++) m |= route_caps(i);
      m[LEG0_APIC] = 1'b1;
      m[LEG1_LINE] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] reach_pic(input int unsigned nt);
      logic [31:0] m;
      m = '0;
      for (int unsigned i = 0; i < nt; i++) m |= route_caps(i) & 32'h0000_FFFF;
      m[LEG0_PIC]  = 1'b1;
      m[LEG1_LINE] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/trt_req_stage.sv
module trt_req_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic clr,
   input  logic level,
   output logic req
);

   logic sts_q;
   logic pulse_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= fire & ~level;
         sts_q   <= level & (fire | (sts_q & ~clr));
      end
   end

   assign req = sts_q | pulse_q;

   AST_EDGE_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> $past(fire && !level)); // R7
   AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q && !fire |=> !pulse_q); // R7
   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sts_q && level && !clr |=> sts_q); // R8
   AST_LEVEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      sts_q && level && clr && !fire |=> !sts_q); // R8

endmodule

// File: rtl/trt_route_dec.sv
module trt_route_dec #(
   parameter int unsigned TIMER_IDX  = 0,
   parameter int unsigned ROUTE_W    = trt_pkg::ROUTE_W_DEF,
   parameter int unsigned PIC_LINES  = trt_pkg::PIC_LINES_DEF,
   parameter int unsigned APIC_LINES = trt_pkg::APIC_LINES_DEF
) (
   input  logic [ROUTE_W-1:0]    route,
   input  logic                  legacy,
   output logic [PIC_LINES-1:0]  pic_sel,
   output logic [APIC_LINES-1:0] apic_sel
);

   localparam logic [31:0] CAPS = trt_pkg::route_caps(TIMER_IDX);
   localparam bit HAS_OVERRIDE  = (TIMER_IDX < 2);

   logic                  legal;
   logic [PIC_LINES-1:0]  std_pic;
   logic [APIC_LINES-1:0] std_apic;

   always_comb begin
      legal    = 1'b0;
      std_pic  = '0;
      std_apic = '0;
      for (int unsigned k = 0; k < APIC_LINES; k++)
         if (CAPS[k] && route == ROUTE_W'(k)) legal = 1'b1;
      if (legal) begin
         for (int unsigned k = 0; k < APIC_LINES; k++) std_apic[k] = (route == ROUTE_W'(k));
         for (int unsigned k = 0; k < PIC_LINES; k++)  std_pic[k]  = (route == ROUTE_W'(k));
      end
   end

   if (HAS_OVERRIDE) begin : g_override
      localparam int unsigned LP = (TIMER_IDX == 0) ? trt_pkg::LEG0_PIC  : trt_pkg::LEG1_LINE;
      localparam int unsigned LA = (TIMER_IDX == 0) ? trt_pkg::LEG0_APIC : trt_pkg::LEG1_LINE;
      logic [PIC_LINES-1:0]  fix_pic;
      logic [APIC_LINES-1:0] fix_apic;
      always_comb begin
         fix_pic      = '0;
         fix_pic[LP]  = 1'b1;
         fix_apic     = '0;
         fix_apic[LA] = 1'b1;
      end
      assign pic_sel  = legacy ? fix_pic  : std_pic;
      assign apic_sel = legacy ? fix_apic : std_apic;
   end else begin : g_plain
      logic unused_legacy;
      assign unused_legacy = legacy;
      assign pic_sel  = std_pic;
      assign apic_sel = std_apic;
   end

   always_comb begin
      if (!(legacy && HAS_OVERRIDE) && !legal)
         AST_BAD_ROUTE_SILENT: assert (pic_sel == '0 && apic_sel == '0); // R4
      if (legacy && TIMER_IDX == 0)
         AST_OVERRIDE_T0: assert (pic_sel[trt_pkg::LEG0_PIC] && apic_sel[trt_pkg::LEG0_APIC]); // R5
   end

endmodule

// File: rtl/trt_irq_merge.sv
module trt_irq_merge #(
   parameter int unsigned NUM_TIMERS = trt_pkg::MAX_TIMERS,
   parameter int unsigned LINES      = trt_pkg::APIC_LINES_DEF
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_TIMERS-1:0]       req,
   input  logic [NUM_TIMERS*LINES-1:0] sel_flat,
   output logic [LINES-1:0]            irq_q
);

   logic [LINES-1:0] acc;

   always_comb begin
      acc = '0;
      for (int unsigned t = 0; t < NUM_TIMERS; t++)
         if (req[t]) acc |= sel_flat[t*LINES +: LINES];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= acc;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req == '0 |=> irq_q == '0); // R3

endmodule

// File: rtl/timer_irq_router.sv
module timer_irq_router
   import trt_pkg::*;
#(
   parameter int unsigned NUM_TIMERS = MAX_TIMERS,
   parameter int unsigned ROUTE_W    = ROUTE_W_DEF,
   parameter int unsigned PIC_LINES  = PIC_LINES_DEF,
   parameter int unsigned APIC_LINES = APIC_LINES_DEF
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             legacy_repl,
   input  logic [NUM_TIMERS-1:0]            tmr_fire,
   input  logic [NUM_TIMERS-1:0]            tmr_clr,
   input  logic [NUM_TIMERS-1:0]            tmr_level,
   input  logic [NUM_TIMERS*ROUTE_W-1:0]    tmr_route,
   output logic [PIC_LINES-1:0]             pic_irq,
   output logic [APIC_LINES-1:0]            apic_irq,
   output logic [NUM_TIMERS*APIC_LINES-1:0] tmr_cap
);

   localparam logic [31:0] REACH_A = reach_apic(NUM_TIMERS);
   localparam logic [31:0] REACH_P = reach_pic(NUM_TIMERS);

   if (NUM_TIMERS < 2 || NUM_TIMERS > MAX_TIMERS) begin : g_bad_timers
      $error("timer_irq_router: NUM_TIMERS must be 2..4");
   end
   if (APIC_LINES < SHARED_HI + 1 || APIC_LINES > 32) begin : g_bad_apic
      $error("timer_irq_router: APIC_LINES must be 24..32");
   end
   if (PIC_LINES <= T3_PRIV || PIC_LINES > APIC_LINES) begin : g_bad_pic
      $error("timer_irq_router: PIC_LINES out of range");
   end
   if ((1 << ROUTE_W) < APIC_LINES) begin : g_bad_route
      $error("timer_irq_router: ROUTE_W too narrow for APIC_LINES");
   end

   logic [NUM_TIMERS-1:0]            t_req;
   logic [NUM_TIMERS*PIC_LINES-1:0]  pic_sel_flat;
   logic [NUM_TIMERS*APIC_LINES-1:0] apic_sel_flat;

   for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
      localparam logic [31:0] CAPS = route_caps(t);

      assign tmr_cap[t*APIC_LINES +: APIC_LINES] = CAPS[APIC_LINES-1:0];

      trt_req_stage u_req (
         .clk   (clk),
         .rst_n (rst_n),
         .fire  (tmr_fire[t]),
         .clr   (tmr_clr[t]),
         .level (tmr_level[t]),
         .req   (t_req[t])
      );

      trt_route_dec #(
         .TIMER_IDX  (t),
         .ROUTE_W    (ROUTE_W),
         .PIC_LINES  (PIC_LINES),
         .APIC_LINES (APIC_LINES)
      ) u_dec (
         .route    (tmr_route[t*ROUTE_W +: ROUTE_W]),
         .legacy   (legacy_repl),
         .pic_sel  (pic_sel_flat[t*PIC_LINES +: PIC_LINES]),
         .apic_sel (apic_sel_flat[t*APIC_LINES +: APIC_LINES])
      );
   end

   trt_irq_merge #(.NUM_TIMERS(NUM_TIMERS), .LINES(PIC_LINES)) u_pic_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (t_req),
      .sel_flat (pic_sel_flat),
      .irq_q    (pic_irq)
   );

   trt_irq_merge #(.NUM_TIMERS(NUM_TIMERS), .LINES(APIC_LINES)) u_apic_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (t_req),
      .sel_flat (apic_sel_flat),
      .irq_q    (apic_irq)
   );

   AST_NO_STRAY_APIC: assert property (@(posedge clk) disable iff (!rst_n)
      (apic_irq & ~REACH_A[APIC_LINES-1:0]) == '0); // R4
   AST_NO_STRAY_PIC: assert property (@(posedge clk) disable iff (!rst_n)
      (pic_irq & ~REACH_P[PIC_LINES-1:0]) == '0); // R4
   AST_OVERRIDE_T1: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_repl && t_req[1] |=> pic_irq[LEG1_LINE] && apic_irq[LEG1_LINE]); // R5

endmodule

// File: tb/tb_timer_irq_router.sv
module tb_timer_irq_router;

   localparam int NT = 4;
   localparam int RW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          legacy_repl = 1'b0;
   logic [NT-1:0] tmr_fire = '0;
   logic [NT-1:0] tmr_clr = '0;
   logic [NT-1:0] tmr_level = '0;
   logic [NT*RW-1:0] tmr_route = '0;
   logic [15:0]   pic_irq;
   logic [23:0]   apic_irq;
   logic [NT*24-1:0] tmr_cap;

   int checks = 0;
   int failures = 0;

   typedef struct {
      logic [15:0] pic;
      logic [23:0] apic;
      string       tag;
   } exp_t;

   exp_t q[$];
   logic [NT-1:0] m_sts = '0;
   logic [NT-1:0] m_pls = '0;

   always #2ns clk = ~clk;

   timer_irq_router dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .legacy_repl (legacy_repl),
      .tmr_fire    (tmr_fire),
      .tmr_clr     (tmr_clr),
      .tmr_level   (tmr_level),
      .tmr_route   (tmr_route),
      .pic_irq     (pic_irq),
      .apic_irq    (apic_irq),
      .tmr_cap     (tmr_cap)
   );

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   task automatic set_route(input int t, input int val);
      tmr_route[t*RW +: RW] = RW'(val);
   endtask

   function automatic bit legal_route(input int t, input int r);
      if (r >= 20 && r <= 23) return 1'b1;
      if (t == 2 && r == 11) return 1'b1;
      if (t == 3 && r == 12) return 1'b1;
      return 1'b0;
   endfunction

   // expected outputs from the requirement text (R3..R6, R9)
   function automatic exp_t model_out(input logic [NT-1:0] rq);
      exp_t e;
      e.pic = '0;
      e.apic = '0;
      e.tag = "";
      for (int i = 0; i < NT; i++) begin
         if (rq[i]) begin
            if (legacy_repl && i == 0) begin
               e.pic[0] = 1'b1; e.apic[2] = 1'b1;
            end else if (legacy_repl && i == 1) begin
               e.pic[8] = 1'b1; e.apic[8] = 1'b1;
            end else begin
               int r;
               r = int'(tmr_route[i*RW +: RW]);
               if (legal_route(i, r)) begin
                  e.apic[r] = 1'b1;
                  if (r < 16) e.pic[r] = 1'b1;
               end
            end
         end
      end
      return e;
   endfunction

   // driver: one cycle of stimulus, pushes the item the monitor will see after this edge
   task automatic step(input logic [NT-1:0] f, input logic [NT-1:0] c, input string tag);
      exp_t e;
      @(negedge clk);
      tmr_fire = f;
      tmr_clr  = c;
      e = model_out(m_sts | m_pls);
      e.tag = tag;
      q.push_back(e);
      for (int i = 0; i < NT; i++) begin
         m_pls[i] = f[i] & ~tmr_level[i];
         m_sts[i] = tmr_level[i] & (f[i] | (m_sts[i] & ~c[i]));
      end
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #1ns;
         if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (pic_irq !== e.pic || apic_irq !== e.apic) begin
               failures++;
               $display("FAIL %s pic act=%h exp=%h apic act=%h exp=%h",
                        e.tag, pic_irq, e.pic, apic_irq, e.apic);
            end
         end
      end
   end

   initial begin
      #800000ns;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   task automatic check_cap(input int t, input logic [23:0] exp);
      checks++;
      if (tmr_cap[t*24 +: 24] !== exp) begin
         failures++;
         $display("FAIL R2 timer %0d cap act=%h exp=%h", t, tmr_cap[t*24 +: 24], exp);
      end
   endtask

   initial begin
      // R1: outputs quiet under reset even with activity on inputs
      tmr_level = 4'b1111;
      set_route(0, 20); set_route(1, 21); set_route(2, 11); set_route(3, 12);
      repeat (3) @(negedge clk);
      tmr_fire = 4'b1111;
      repeat (3) @(negedge clk);
      checks++;
      if (pic_irq !== '0 || apic_irq !== '0) begin
         failures++;
         $display("FAIL R1 in reset pic act=%h exp=0 apic act=%h exp=0", pic_irq, apic_irq);
      end
      tmr_fire = '0;
      tmr_level = '0;
      rst_n = 1'b1;

      // R2: capability masks
      check_cap(0, 24'hF00000);
      check_cap(1, 24'hF00000);
      check_cap(2, 24'hF00800);
      check_cap(3, 24'hF01000);

      // R1: first cycle after reset is quiet
      step(4'b0000, 4'b0000, "R1");

      // R3 / R7: standard routing, edge mode, one timer at a time
      step(4'b0001, 4'b0000, "R3");
      step(4'b0010, 4'b0000, "R3");
      step(4'b0100, 4'b0000, "R3");
      step(4'b1000, 4'b0000, "R7");
      step(4'b0000, 4'b0000, "R7");
      step(4'b0000, 4'b0000, "R7");
      // R7: back-to-back strobes give back-to-back pulses
      step(4'b0100, 4'b0000, "R7");
      step(4'b0100, 4'b0000, "R7");
      step(4'b0000, 4'b0000, "R7");
      step(4'b0000, 4'b0000, "R7");

      // R4: illegal routes stay silent
      set_route(0, 11); set_route(1, 2); set_route(2, 12); set_route(3, 24);
      step(4'b1111, 4'b0000, "R4");
      step(4'b0000, 4'b0000, "R4");
      set_route(0, 31); set_route(1, 19); set_route(2, 0); set_route(3, 11);
      step(4'b1111, 4'b0000, "R4");
      step(4'b0000, 4'b0000, "R4");
      step(4'b0000, 4'b0000, "R4");

      // R5 / R6: legacy override
      legacy_repl = 1'b1;
      set_route(0, 20); set_route(1, 21); set_route(2, 22); set_route(3, 12);
      step(4'b0001, 4'b0000, "R5");
      step(4'b0010, 4'b0000, "R5");
      step(4'b0100, 4'b0000, "R6");
      step(4'b1000, 4'b0000, "R6");
      step(4'b0000, 4'b0000, "R6");
      set_route(0, 5); set_route(1, 31); set_route(2, 5);
      step(4'b0111, 4'b0000, "R5");
      step(4'b0000, 4'b0000, "R6");
      step(4'b0000, 4'b0000, "R6");

      // R8: level mode hold and clear
      legacy_repl = 1'b0;
      tmr_level = 4'b1111;
      set_route(0, 20); set_route(1, 21); set_route(2, 11); set_route(3, 23);
      step(4'b0100, 4'b0000, "R8");
      step(4'b0000, 4'b0000, "R8");
      step(4'b0000, 4'b0000, "R8");
      step(4'b0000, 4'b0000, "R8");
      step(4'b0000, 4'b0100, "R8");
      step(4'b0000, 4'b0000, "R8");
      step(4'b0000, 4'b0000, "R8");
      // R8: match and clear together keeps the line held
      step(4'b1000, 4'b0000, "R8");
      step(4'b1000, 4'b1000, "R8");
      step(4'b0000, 4'b0000, "R8");
      step(4'b0000, 4'b1000, "R8");
      step(4'b0000, 4'b0000, "R8");
      step(4'b0000, 4'b0000, "R8");

      // R9: shared level line stays until both holders clear
      set_route(0, 22); set_route(1, 22);
      step(4'b0001, 4'b0000, "R9");
      step(4'b0010, 4'b0000, "R9");
      step(4'b0000, 4'b0001, "R9");
      step(4'b0000, 4'b0000, "R9");
      step(4'b0000, 4'b0000, "R9");
      step(4'b0000, 4'b0010, "R9");
      step(4'b0000, 4'b0000, "R9");
      step(4'b0000, 4'b0000, "R9");

      // R9: edge pulses from two timers merged on one line, plus distinct lines
      tmr_level = 4'b0000;
      set_route(2, 20); set_route(3, 20); set_route(0, 21); set_route(1, 23);
      step(4'b1100, 4'b0000, "R9");
      step(4'b1111, 4'b0000, "R9");
      step(4'b0000, 4'b0000, "R9");
      step(4'b0000, 4'b0000, "R9");

      // drain
      step(4'b0000, 4'b0000, "R3");
      step(4'b0000, 4'b0000, "R3");
      @(negedge clk);
      @(negedge clk);
      summary();
      $finish;
   end

endmodule